// File: doc/BRIEF.md
# Serial port register front end

This block is the register-level front end of a serial port. It sits on a simple memory-mapped bus with read and write strobes, a byte address into a window of 0x2000 bytes, 32-bit write data and combinational 32-bit read data. It holds a status register, a data register, a baud divisor, three control registers and a guard-time register. Reads and writes change the status flags. One level-sensitive interrupt line reports that a received byte is waiting.

Bytes move whole, in one cycle, on two valid/ready streams. On the transmit stream the block is the producer. A write to the data register loads a byte and raises `tx_valid`. The byte and `tx_valid` then stay unchanged until a cycle in which `tx_ready` is high, except that a further accepted data write replaces the pending byte. On the receive stream the block is the consumer. `rx_ready` is high exactly while the receive-not-empty flag is clear, so the source must hold its byte until the software empties the data register. Serial bit timing, parity, framing and FIFOs are outside this block.

Within one cycle the bus access takes effect first and the receive handshake second. Registers are at byte offsets 0x00 status, 0x04 data, 0x08 baud, 0x0C control 1, 0x10 control 2, 0x14 control 3 and 0x18 guard time. Every other address in the window, including unaligned ones, is unmapped.

Top module: `serial_port_regfile`

## Requirements
- R1: After reset the status register reads 0x000000C0, every other register reads zero, `irq` is low, `tx_valid` is low and `rx_ready` is high.
- R2: `rx_ready` equals the inverse of status bit 5 (receive-not-empty). While that bit is set, an offered byte is not taken and the data register keeps its old byte.
- R3: An accepted receive byte is always written to the data register. Status bit 5 is set only when control-1 bit 13 (enable) and bit 2 (receiver enable) are both 1.
- R4: An accepted byte that sets bit 5 while control-1 bit 5 (receive interrupt enable) is 1 drives `irq` high from the next cycle.
- R5: A status read returns the value held before the access. Status bit 6 (transmit-complete) is then cleared.
- R6: A data read returns the data register masked to its low 10 bits. It sets status bit 7 (transmit-empty), clears bit 5 and drives `irq` low.
- R7: A status write of at most 0x3FF replaces the register. A larger value is ANDed into it. If bit 5 is then clear, `irq` goes low; otherwise `irq` keeps its level.
- R8: A data write below 0xF000 puts its low byte on the transmit stream, sets bit 6 and clears bit 7. A data write of 0xF000 or more changes nothing.
- R9: `tx_valid` and `tx_data` hold until a cycle with `tx_ready` high. A data write accepted while a byte is pending replaces that byte.
- R10: A control-1 write stores the value. If the new bit 5 is 1 and status bit 5 is 1, `irq` goes high.
- R11: Baud, control 2, control 3 and guard time are plain read/write storage. Unmapped reads return zero and unmapped writes change no register.
- R12: When a data read and a receive handshake fall in the same cycle, the read's effects apply first. The new byte then sets bit 5 and, if enabled, `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 13 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high, zero otherwise |
| irq | output | 1 | Level interrupt: a received byte is waiting |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Block can take a receive byte |
| rx_data | input | 8 | Receive byte |

## Verification
The bench offers bytes while the receiver is disabled. A design that gated the data store on the enables, rather than only the flag, would read back a stale byte. It writes the status register on both sides of the 0x3FF limit and with 0x400, which a design using one merge rule would turn into a wrong non-zero value. It also writes data at 0xEFFF and at 0xF000. It tests the interrupt paths that hold or drop the level: an AND-write that keeps receive-not-empty must leave `irq` high, and a control-1 write must raise it for a byte already waiting. Finally it stalls the transmit sink across a replacement write and issues a data read in the same cycle a byte arrives. A design with the reversed order would lose the new byte's flag.

// File: rtl/sp_regs_pkg.sv
package sp_regs_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 13;
  localparam int unsigned NUM_REGS = 7;
  localparam int unsigned NUM_PLAIN = 5;

  // register index = byte offset / 4
  localparam int unsigned IDX_STAT = 0;
  localparam int unsigned IDX_DATA = 1;
  localparam int unsigned IDX_BAUD = 2;
  localparam int unsigned IDX_CTL1 = 3;
  localparam int unsigned IDX_CTL2 = 4;
  localparam int unsigned IDX_CTL3 = 5;
  localparam int unsigned IDX_GUARD = 6;

  // status bits
  localparam int unsigned ST_RXFULL = 5;
  localparam int unsigned ST_TXDONE = 6;
  localparam int unsigned ST_TXFREE = 7;
  localparam logic [DATA_W-1:0] STAT_RESET = 32'h0000_00C0;

  // control 1 bits
  localparam int unsigned C1_RXON  = 2;
  localparam int unsigned C1_RXIEN = 5;
  localparam int unsigned C1_ON    = 13;

  localparam logic [DATA_W-1:0] STAT_REPLACE_MAX = 32'h0000_03FF;
  localparam logic [DATA_W-1:0] DATA_SEND_LIMIT  = 32'h0000_F000;
  localparam logic [DATA_W-1:0] DATA_READ_MASK   = 32'h0000_03FF;

  function automatic logic [DATA_W-1:0] stat_merge(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] val);
    return (val <= STAT_REPLACE_MAX) ? val : (cur & val);
  endfunction
endpackage

// File: rtl/sp_addr_decode.sv
module sp_addr_decode #(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned NUM_REGS = 7
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i * 4));
  end
endmodule

// File: rtl/sp_plain_regs.sv
module sp_plain_regs #(
  parameter int unsigned NUM = 5,
  parameter int unsigned DW  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM-1:0]        wr_sel,
  input  logic [DW-1:0]         wdata,
  output logic [NUM-1:0][DW-1:0] q
);
  for (genvar i = 0; i < NUM; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)         q[i] <= '0;
      else if (wr_sel[i]) q[i] <= wdata;
    end
  end
endmodule

// File: rtl/sp_flag_unit.sv
module sp_flag_unit
  import sp_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stat,
  input  logic              rd_data,
  input  logic              wr_stat,
  input  logic              wr_data,
  input  logic              wr_ctl1,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ctl1_eff,
  output logic [DATA_W-1:0] stat_q,
  output logic [7:0]        data_q,
  output logic              irq,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data
);
  logic [DATA_W-1:0] stat_n;
  logic [7:0]        data_n, txd_n;
  logic              irq_n, txv_n, rx_take, send_ok;

  assign rx_ready = !stat_q[ST_RXFULL];
  assign rx_take  = rx_valid && rx_ready;
  assign send_ok  = wr_data && (wdata < DATA_SEND_LIMIT);

  // bus effects first, receive handshake last
  always_comb begin
    stat_n = stat_q;
    data_n = data_q;
    irq_n  = irq;
    txv_n  = tx_valid && !tx_ready;
    txd_n  = tx_data;
    if (rd_stat) stat_n[ST_TXDONE] = 1'b0;
    if (rd_data) begin
      stat_n[ST_TXFREE] = 1'b1;
      stat_n[ST_RXFULL] = 1'b0;
      irq_n = 1'b0;
    end
    if (wr_stat) begin
      stat_n = stat_merge(stat_n, wdata);
      if (!stat_n[ST_RXFULL]) irq_n = 1'b0;
    end
    if (send_ok) begin
      txv_n = 1'b1;
      txd_n = wdata[7:0];
      stat_n[ST_TXDONE] = 1'b1;
      stat_n[ST_TXFREE] = 1'b0;
    end
    if (wr_ctl1 && wdata[C1_RXIEN] && stat_n[ST_RXFULL]) irq_n = 1'b1;
    if (rx_take) begin
      data_n = rx_data;
      if (ctl1_eff[C1_ON] && ctl1_eff[C1_RXON]) begin
        stat_n[ST_RXFULL] = 1'b1;
        if (ctl1_eff[C1_RXIEN]) irq_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q   <= STAT_RESET;
      data_q   <= '0;
      irq      <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      stat_q   <= stat_n;
      data_q   <= data_n;
      irq      <= irq_n;
      tx_valid <= txv_n;
      tx_data  <= txd_n;
    end
  end

  // R5: status read clears transmit-complete
  a_r5_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !wr_stat && !wr_data |=> !stat_q[ST_TXDONE]);
  // R6: data read side effects
  a_r6_data_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !rx_take && !wr_stat && !wr_data |=> stat_q[ST_TXFREE] && !stat_q[ST_RXFULL] && !irq);
  // R8: accepted data write drives the transmit stream
  a_r8_send: assert property (@(posedge clk) disable iff (!rst_n)
    send_ok |=> tx_valid && tx_data == $past(wdata[7:0]) && stat_q[ST_TXDONE] && !stat_q[ST_TXFREE]);
  // R9: pending byte held under back-pressure
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !send_ok |=> tx_valid && $stable(tx_data));
  // R4: enabled receive raises the interrupt
  a_r4_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take && ctl1_eff[C1_ON] && ctl1_eff[C1_RXON] && ctl1_eff[C1_RXIEN] |=> irq && stat_q[ST_RXFULL]);
  // R3: disabled receive stores the byte but leaves the flag clear
  a_r3_rx_store: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take && !(ctl1_eff[C1_ON] && ctl1_eff[C1_RXON]) && !wr_stat
    |=> !stat_q[ST_RXFULL] && data_q == $past(rx_data));
  // R2: a full receiver keeps its byte
  a_r2_rx_block: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |=> $stable(data_q));
endmodule

// File: rtl/serial_port_regfile.sv
module serial_port_regfile
  import sp_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data
);
  logic [NUM_REGS-1:0]              sel;
  logic [NUM_REGS-1:0]              wsel;
  logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q;
  logic [NUM_REGS-1:0][DATA_W-1:0]  view;
  logic [DATA_W-1:0]                stat_q, ctl1_eff, rd_mux;
  logic [7:0]                       data_q;

  sp_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr(bus_addr), .sel(sel));

  assign wsel = bus_wr ? sel : '0;

  // plain slots: baud, ctl1, ctl2, ctl3, guard
  sp_plain_regs #(.NUM(NUM_PLAIN), .DW(DATA_W)) u_plain (
    .clk(clk), .rst_n(rst_n),
    .wr_sel(wsel[NUM_REGS-1:IDX_BAUD]),
    .wdata(bus_wdata), .q(plain_q));

  assign ctl1_eff = wsel[IDX_CTL1] ? bus_wdata : plain_q[IDX_CTL1-IDX_BAUD];

  sp_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n),
    .rd_stat(bus_rd && sel[IDX_STAT]),
    .rd_data(bus_rd && sel[IDX_DATA]),
    .wr_stat(wsel[IDX_STAT]),
    .wr_data(wsel[IDX_DATA]),
    .wr_ctl1(wsel[IDX_CTL1]),
    .wdata(bus_wdata),
    .ctl1_eff(ctl1_eff),
    .stat_q(stat_q), .data_q(data_q), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data));

  assign view[IDX_STAT] = stat_q;
  assign view[IDX_DATA] = {{(DATA_W-8){1'b0}}, data_q} & DATA_READ_MASK;
  for (genvar i = IDX_BAUD; i < NUM_REGS; i++) begin : g_view
    assign view[i] = plain_q[i-IDX_BAUD];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel[i]) rd_mux = rd_mux | view[i];
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  // R11: at most one register decoded per address
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));
endmodule

// File: tb/sim_serial_port_regfile.sv
module sim_serial_port_regfile;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
  logic [7:0]  tx_data, rx_data = '0;
  int checks = 0, fails = 0;
  logic [31:0] rv;
  logic        ok;

  always #(PERIOD/2) clk = ~clk;

  serial_port_regfile u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, output logic took);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    #1 took = rx_ready;
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0); chk("R1 tx_valid", tx_valid, 0); chk("R1 rx_ready", rx_ready, 1);
    rd(13'h00, rv); chk("R1 status", rv, 32'hC0);
    rd(13'h0C, rv); chk("R1 ctl1", rv, 0);
    rd(13'h08, rv); chk("R1 baud", rv, 0);
    rd(13'h18, rv); chk("R1 guard", rv, 0);
  endtask

  task automatic t_plain();
    wr(13'h08, 32'h1234_5678); wr(13'h10, 32'hA5A5_0001);
    wr(13'h14, 32'h0000_FFFF); wr(13'h18, 32'hDEAD_BEEF);
    wr(13'h1C, 32'hFFFF_FFFF); wr(13'h09, 32'h0);
    rd(13'h08, rv); chk("R11 baud", rv, 32'h1234_5678);
    rd(13'h10, rv); chk("R11 ctl2", rv, 32'hA5A5_0001);
    rd(13'h14, rv); chk("R11 ctl3", rv, 32'h0000_FFFF);
    rd(13'h18, rv); chk("R11 guard", rv, 32'hDEAD_BEEF);
    rd(13'h1C, rv); chk("R11 unmapped 1C", rv, 0);
    rd(13'h05, rv); chk("R11 unaligned", rv, 0);
    rd(13'h1FFC, rv); chk("R11 window top", rv, 0);
  endtask

  task automatic t_rx_disabled();
    wr(13'h0C, 32'h0); wr(13'h00, 32'hC0);
    push(8'h5A, ok); chk("R3 taken", ok, 1);
    chk("R3 irq", irq, 0);
    rd(13'h00, rv); chk("R3 flag off", rv, 32'hC0);
    rd(13'h04, rv); chk("R3 byte stored", rv, 32'h5A);
    wr(13'h0C, 32'h0000_0024);
    push(8'h5B, ok);
    rd(13'h00, rv); chk("R3 no enable", rv, 32'h80);
    rd(13'h04, rv); chk("R3 byte 2", rv, 32'h5B);
  endtask

  task automatic t_rx_irq();
    wr(13'h0C, 32'h2024); wr(13'h00, 32'hC0);
    push(8'hA5, ok); chk("R2 taken", ok, 1);
    chk("R4 irq", irq, 1); chk("R2 rx_ready low", rx_ready, 0);
    rd(13'h00, rv); chk("R5 status value", rv, 32'hE0);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h11;
    for (int i = 0; i < 3; i++) begin
      #1 chk("R2 hold-off", rx_ready, 0);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rd(13'h04, rv); chk("R6 data", rv, 32'hA5);
    chk("R6 irq low", irq, 0); chk("R6 rx_ready", rx_ready, 1);
    rd(13'h00, rv); chk("R6 R5 status", rv, 32'h80);
  endtask

  task automatic t_ctl_irq();
    wr(13'h0C, 32'h2004); wr(13'h00, 32'hC0);
    push(8'h3C, ok); chk("R4 no irq without enable", irq, 0);
    wr(13'h0C, 32'h2024); chk("R10 irq on ctl1 write", irq, 1);
    wr(13'h00, 32'h80); chk("R7 irq drop", irq, 0);
    rd(13'h00, rv); chk("R7 replace", rv, 32'h80);
    rd(13'h04, rv); chk("R6 data kept", rv, 32'h3C);
    push(8'h3D, ok); chk("R4 irq", irq, 1);
    wr(13'h00, 32'hFFFF_FFFF); chk("R7 irq kept", irq, 1);
    rd(13'h00, rv); chk("R7 and keeps", rv, 32'hA0);
    rd(13'h04, rv); chk("R6 data 3D", rv, 32'h3D);
  endtask

  task automatic t_stat_rule();
    wr(13'h0C, 32'h0);
    wr(13'h00, 32'h3FF); rd(13'h00, rv); chk("R7 replace 3FF", rv, 32'h3FF);
    wr(13'h00, 32'hFFFF_FFDF); rd(13'h00, rv); chk("R7 and mask", rv, 32'h39F);
    wr(13'h00, 32'h400); rd(13'h00, rv); chk("R7 and 400", rv, 0);
    wr(13'h00, 32'hC0);
  endtask

  task automatic t_tx();
    tx_ready = 1'b0;
    wr(13'h04, 32'hE142); chk("R8 valid", tx_valid, 1); chk("R8 byte", tx_data, 32'h42);
    repeat (2) @(negedge clk);
    chk("R9 held", {tx_valid, tx_data}, {1'b1, 8'h42});
    wr(13'h04, 32'h0043); chk("R9 replace", tx_data, 32'h43);
    rd(13'h00, rv); chk("R8 flags", rv, 32'h40);
    @(negedge clk); tx_ready = 1'b1; @(posedge clk); #1 tx_ready = 1'b0;
    chk("R9 drained", tx_valid, 0);
    wr(13'h04, 32'hF000); chk("R8 F000 ignored", tx_valid, 0);
    wr(13'h04, 32'hFFFF_FF55); chk("R8 big ignored", tx_valid, 0);
    rd(13'h00, rv); chk("R8 status unchanged", rv, 32'h00);
    wr(13'h04, 32'hEFFF); chk("R8 EFFF sends", tx_data, 32'hFF);
    @(negedge clk); tx_ready = 1'b1; @(posedge clk); #1 chk("R9 drained 2", tx_valid, 0);
  endtask

  task automatic t_same_cycle();
    wr(13'h00, 32'hC0); wr(13'h0C, 32'h2024);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 13'h04; rx_valid = 1'b1; rx_data = 8'h77;
    @(posedge clk); #1 bus_rd = 1'b0; rx_valid = 1'b0;
    chk("R12 irq", irq, 1); chk("R12 full", rx_ready, 0);
    rd(13'h04, rv); chk("R12 new byte", rv, 32'h77);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_rx_disabled();
    t_rx_irq();
    t_ctl_irq();
    t_stat_rule();
    t_tx();
    t_same_cycle();
    report();
  end
endmodule